// File: doc/BRIEF.md
# Multi-bank level interrupt aggregator

This block collects a parameterised number of 32-bit words of level-sensitive interrupt sources and presents them to several CPU targets. Each CPU target owns a register bank holding its own mask. That bank drives its own interrupt line to a parent controller. Each source is brought into the clock domain by a two-flop synchroniser before anything reads it.

Software reaches one bank at a time through a 32-bit register port. `reg_cpu` picks the bank and `reg_addr` picks a register inside it. A bank of N words holds four groups of N registers, in this order:

- the raw source levels,
- the current mask,
- a write-one-to-mask port,
- a write-one-to-unmask port.

Software steers a source to a CPU by unmasking it only in that CPU's bank. Sources are level-sensitive, so nothing is cleared by reads or writes. A source stays pending until its device drops it.

Top module: `l1_irq_aggregator`

## Requirements
- R1: After reset every mask bit of every bank is 1, every `cpu_irq` bit is 0, and the raw level registers read 0.
- R2: The raw level register of word w returns the source levels `src_lvl[32w+31:32w]`, unmasked. A change on `src_lvl` becomes visible after the second rising clock edge.
- R3: Register byte offsets are (g*N + w)*4. Here w is the word index and g is the group: 0 raw levels, 1 mask read-back, 2 mask-set, 3 mask-clear. `reg_cpu` selects the bank, and `reg_addr[1:0]` are ignored.
- R4: Writing to the mask-set group sets each mask bit written as 1 and leaves bits written as 0 unchanged.
- R5: Writing to the mask-clear group clears each mask bit written as 1 and leaves bits written as 0 unchanged.
- R6: The mask read-back group returns the bank's current mask word, where 1 means the source is disabled.
- R7: Writes to the raw level group or the mask read-back group change no mask. Reads of the mask-set and mask-clear groups return 0.
- R8: `cpu_irq[c]` is a registered signal. It is 1 when any bit of (levels AND NOT mask) of bank c is set in any word. It follows a change one clock edge after the levels or the mask change.
- R9: Each bank's mask is independent. Writes addressed to one bank leave the masks and interrupt outputs of every other bank unchanged.
- R10: A pending source stays pending, and its interrupt stays asserted, while the source is held high, regardless of reads. It is removed only when the source is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lvl | input | 32*NWORDS | Asynchronous level-sensitive interrupt sources |
| reg_cpu | input | max(1,clog2(NCPU)) | Bank (CPU target) selected for access |
| reg_addr | input | clog2(16*NWORDS) | Byte address inside the bank |
| reg_wr | input | 1 | Write strobe, acted on at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current `reg_cpu`/`reg_addr` (combinational) |
| cpu_irq | output | NCPU | Registered interrupt line per CPU bank |

## Verification
Directed patterns cover three cases:

- A single source steered to one bank. This shows the exact two-edge level latency and the three-edge interrupt latency, and that the other bank stays quiet.
- Writes of 0 bits to the set and clear ports, and writes to the read-only groups. These separate "bits written as 0 leave the mask alone" from a plain overwrite.
- Holding a source across repeated reads. This shows the level is not cleared by reading.

Random phases then drive arbitrary source words and random writes to random banks and groups. Mask, level and interrupt values are compared with a bench model. These phases catch mis-decoded offsets, crossed banks and swapped set and clear semantics.

// File: rtl/l1ic_pkg.sv
// Shared constants and types for the multi-bank interrupt aggregator.
package l1ic_pkg;
    localparam int WORD_BITS = 32;

    // Register group order inside a bank; the address decode depends on it.
    typedef enum logic [1:0] {
        GRP_LEVEL = 2'd0,
        GRP_MASK  = 2'd1,
        GRP_MSET  = 2'd2,
        GRP_MCLR  = 2'd3
    } grp_e;
endpackage

// File: rtl/l1ic_sync.sv
// Two-flop synchroniser for a vector of independent level signals.
// Assumes each bit is a slow level; no bus coherency across bits is implied.
module l1ic_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [1:0]   settle;

    // Two register stages between the asynchronous input and the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= src_in;
            sync_out <= stage1;
        end
    end

    // Counts edges since reset so the latency check only looks at valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)            settle <= 2'd0;
        else if (settle != 2'd2) settle <= settle + 2'd1;
    end

    // R2: output equals the input from two edges earlier.
    a_r2_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        (settle == 2'd2) |-> (sync_out == $past(src_in, 2)));
endmodule

// File: rtl/l1ic_bank.sv
// One CPU bank: per-word mask registers with write-one set / write-one clear,
// and a registered OR-reduction of unmasked pending levels to one output.
// Assumes wr_set and wr_clr are never asserted together (decoder guarantees).
module l1ic_bank #(
    parameter int NWORDS = 2,
    parameter int WSEL_W = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NWORDS*l1ic_pkg::WORD_BITS-1:0] level,
    input  logic                                  wr_set,
    input  logic                                  wr_clr,
    input  logic [WSEL_W-1:0]                     wr_word,
    input  logic [l1ic_pkg::WORD_BITS-1:0]        wdata,
    output logic [NWORDS*l1ic_pkg::WORD_BITS-1:0] mask,
    output logic                                  irq
);
    import l1ic_pkg::*;

    logic [NWORDS-1:0] word_hit;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign word_hit[w] = (wr_word == WSEL_W'(w));

        // Mask word: reset to all-disabled, set or clear only the bits written as 1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[w*WORD_BITS +: WORD_BITS] <= '1;
            else if (wr_set && word_hit[w])
                mask[w*WORD_BITS +: WORD_BITS] <= mask[w*WORD_BITS +: WORD_BITS] | wdata;
            else if (wr_clr && word_hit[w])
                mask[w*WORD_BITS +: WORD_BITS] <= mask[w*WORD_BITS +: WORD_BITS] & ~wdata;
        end
    end

    // Registered output: any unmasked pending level in any word.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(level & ~mask);
    end

    // R4: a set write can only raise mask bits.
    a_r4_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> (($past(mask) & ~mask) == '0));
    // R5: a clear write can only lower mask bits.
    a_r5_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask & ~$past(mask)) == '0));
    // R7/R9: with no write strobe into this bank, the mask holds.
    a_r9_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_set && !wr_clr) |=> $stable(mask));
    // R8: a fully masked bank never raises its line.
    a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> !irq);
    // Decoder contract.
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_set, wr_clr}));
endmodule

// File: rtl/l1_irq_aggregator.sv
// Multi-bank level interrupt aggregator top: synchronises sources, decodes the
// packed register layout (offset = (group*NWORDS + word)*4) per selected bank,
// and instantiates one mask/output bank per CPU target.
// Assumes single-cycle register accesses; read data is combinational.
module l1_irq_aggregator #(
    parameter int NWORDS = 2,
    parameter int NCPU   = 2,
    localparam int SRC_W  = NWORDS * 32,
    localparam int ADDR_W = $clog2(16 * NWORDS),
    localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_lvl,
    input  logic [CPU_W-1:0]  reg_cpu,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NCPU-1:0]   cpu_irq
);
    import l1ic_pkg::*;

    localparam int IDX_W  = ADDR_W - 2;
    localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int N_REGS = 4 * NWORDS;

    logic [SRC_W-1:0]  level;
    logic [IDX_W-1:0]  reg_idx;
    logic              idx_ok;
    logic              cpu_ok;
    grp_e              dec_grp;
    logic [WSEL_W-1:0] dec_word;
    logic [SRC_W-1:0]  bank_mask [NCPU];
    logic [NCPU*SRC_W-1:0] all_mask;

    l1ic_sync #(.W(SRC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_lvl),
        .sync_out (level)
    );

    // Address decode: register index split into group and word.
    always_comb begin
        reg_idx  = reg_addr[ADDR_W-1:2];
        idx_ok   = (32'(reg_idx) < N_REGS);
        cpu_ok   = (32'(reg_cpu) < NCPU);
        dec_grp  = grp_e'(2'(32'(reg_idx) / NWORDS));
        dec_word = WSEL_W'(32'(reg_idx) % NWORDS);
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_bank
        logic hit;
        assign hit = reg_wr && idx_ok && (reg_cpu == CPU_W'(c));

        l1ic_bank #(.NWORDS(NWORDS), .WSEL_W(WSEL_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .level   (level),
            .wr_set  (hit && (dec_grp == GRP_MSET)),
            .wr_clr  (hit && (dec_grp == GRP_MCLR)),
            .wr_word (dec_word),
            .wdata   (reg_wdata),
            .mask    (bank_mask[c]),
            .irq     (cpu_irq[c])
        );
        assign all_mask[c*SRC_W +: SRC_W] = bank_mask[c];
    end

    // Read mux: levels are shared, mask comes from the selected bank.
    always_comb begin
        reg_rdata = '0;
        if (idx_ok && cpu_ok) begin
            case (dec_grp)
                GRP_LEVEL: reg_rdata = level[32'(dec_word)*32 +: 32];
                GRP_MASK:  reg_rdata = bank_mask[reg_cpu][32'(dec_word)*32 +: 32];
                default:   reg_rdata = '0;
            endcase
        end
    end

    // R7: writes to the read-only groups leave every mask unchanged.
    a_r7_ro_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (dec_grp == GRP_LEVEL || dec_grp == GRP_MASK)) |=> $stable(all_mask));
    // R1: the outputs are quiet in the first cycle out of reset.
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (cpu_irq == '0));
endmodule

// File: tb/sim_l1_irq_aggregator.sv
module sim_l1_irq_aggregator;
    localparam int NW = 2;
    localparam int NC = 2;
    localparam int SW = NW * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] src_lvl = '0;
    logic [0:0]    reg_cpu = '0;
    logic [4:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NC-1:0] cpu_irq;

    int errors = 0;
    int checks = 0;
    logic [31:0] mdl_mask [NC][NW];

    always #4 clk = ~clk;

    l1_irq_aggregator #(.NWORDS(NW), .NCPU(NC)) u0 (
        .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_cpu(reg_cpu),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] offs(input int g, input int w);
        return 5'((g * NW + w) * 4);
    endfunction

    function automatic logic exp_irq(input int c);
        logic any = 1'b0;
        for (int w = 0; w < NW; w++)
            any |= |(src_lvl[w*32 +: 32] & ~mdl_mask[c][w]);
        return any;
    endfunction

    // Write at a negedge, strobe across one posedge; model updated alongside.
    task automatic wr(input int c, input int g, input int w, input logic [31:0] d);
        @(negedge clk);
        reg_cpu = 1'(c); reg_addr = offs(g, w); reg_wdata = d; reg_wr = 1'b1;
        if (g == 2) mdl_mask[c][w] |= d;
        if (g == 3) mdl_mask[c][w] &= ~d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int c, input int g, input int w, output logic [31:0] d);
        reg_cpu = 1'(c); reg_addr = offs(g, w);
        #1 d = reg_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int c = 0; c < NC; c++) begin
            check({tag, " R8 irq"}, 32'(cpu_irq[c]), 32'(exp_irq(c)));
            for (int w = 0; w < NW; w++) begin
                rd(c, 0, w, d); check({tag, " R2 level"}, d, src_lvl[w*32 +: 32]);
                rd(c, 1, w, d); check({tag, " R6 mask"}, d, mdl_mask[c][w]);
                rd(c, 2, w, d); check({tag, " R7 set reads 0"}, d, 32'h0);
                rd(c, 3, w, d); check({tag, " R7 clr reads 0"}, d, 32'h0);
            end
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_1234));
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) mdl_mask[c][w] = '1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(cpu_irq), 32'h0);
        for (int c = 0; c < NC; c++)
            for (int w = 0; w < NW; w++) begin
                rd(c, 1, w, d); check("R1 mask all ones", d, 32'hFFFF_FFFF);
                rd(c, 0, w, d); check("R1 level zero", d, 32'h0);
            end

        // R5/R3: unmask word1 bit 5 in bank 0 only
        wr(0, 3, 1, 32'h0000_0020);
        rd(0, 1, 1, d); check("R5 clear bit5", d, 32'hFFFF_FFDF);
        rd(1, 1, 1, d); check("R9 other bank untouched", d, 32'hFFFF_FFFF);
        rd(0, 1, 0, d); check("R3 other word untouched", d, 32'hFFFF_FFFF);

        // R2/R8 latency: source 37 (word1 bit5) rises at a negedge
        src_lvl[37] = 1'b1;
        @(posedge clk); #1; rd(0, 0, 1, d); check("R2 not yet after 1 edge", d, 32'h0);
        @(posedge clk); #1; rd(0, 0, 1, d); check("R2 visible after 2 edges", d, 32'h20);
        check("R8 irq not yet", 32'(cpu_irq[0]), 32'h0);
        @(posedge clk); #1; check("R8 irq after 3 edges", 32'(cpu_irq[0]), 32'h1);
        check("R9 bank1 quiet", 32'(cpu_irq[1]), 32'h0);

        // R10: reads do not clear; level persists
        repeat (5) begin
            @(negedge clk); rd(0, 0, 1, d);
        end
        check("R10 level held", d, 32'h20);
        check("R10 irq held", 32'(cpu_irq[0]), 32'h1);

        // R4: zero bits leave mask alone, then set masks the source
        wr(0, 2, 1, 32'h0000_0000);
        rd(0, 1, 1, d); check("R4 zero write no effect", d, 32'hFFFF_FFDF);
        // R7: writes to read-only groups ignored
        wr(0, 0, 1, 32'h0000_0000);
        wr(0, 1, 1, 32'hFFFF_FFFF);
        rd(0, 1, 1, d); check("R7 ro writes ignored", d, 32'hFFFF_FFDF);
        check("R7 irq still set", 32'(cpu_irq[0]), 32'h1);
        wr(0, 2, 1, 32'h0000_0020);
        @(posedge clk); #1;
        check("R4 set masks irq", 32'(cpu_irq[0]), 32'h0);

        // R10: deassert source removes pending after unmask
        wr(0, 3, 1, 32'h0000_0020);
        @(posedge clk); #1; check("R10 irq back", 32'(cpu_irq[0]), 32'h1);
        @(negedge clk); src_lvl[37] = 1'b0;
        repeat (3) @(posedge clk); #1;
        check("R10 irq drops with source", 32'(cpu_irq[0]), 32'h0);

        // Random phase
        for (int it = 0; it < 150; it++) begin
            @(negedge clk);
            for (int w = 0; w < NW; w++) src_lvl[w*32 +: 32] = $urandom;
            for (int k = 0; k < 3; k++)
                wr($urandom_range(0, NC-1), $urandom_range(0, 3),
                   $urandom_range(0, NW-1), $urandom);
            repeat (3) @(posedge clk);
            @(negedge clk);
            check_all("rand");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule